// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block sits in front of a pair of timer/counters and decides, every system clock cycle, whether each of them may advance. It holds one free-running 10-bit prescaler that both timers share. Each timer has a 3-bit source select. The select can stop the timer, pass the undivided system clock, pick one of four prescaler taps, or follow edges on the timer's own external pin. The block delivers one single-cycle count-enable strobe per timer. The counters, compare and capture logic, and interrupts sit elsewhere.

The external pin is asynchronous. Each pin passes through a two-flop synchronizer and then an edge detector, which gives one strobe per qualifying edge. This path never goes through the prescaler.

Software can realign the shared prescaler by writing one to a control bit. The write zeroes the prescaler count on the next edge, and the bit itself never reads back as one. Both timers take their taps from the same count, so one write moves the tap phase of both.

Top module: `tmrpre_top`

## Requirements
- R1: A timer whose select is 000 gets no count-enable strobe.
- R2: A timer whose select is 001 gets a strobe in every cycle once the block is out of reset.
- R3: Selects 010, 011, 100 and 101 make a strobe in each cycle where the low 3, 6, 8 or 10 bits of the shared 10-bit prescaler count are all ones. This gives one strobe every 8, 64, 256 or 1024 cycles.
- R4: Raising the control write strobe with write data 1 in cycle W makes the prescaler count zero in cycle W+1. A divide-by-N select therefore strobes first in cycle W+N and every N cycles after that.
- R5: A control write with write data 0 leaves the prescaler count and the tap phase unchanged.
- R6: The control read-back bit is 0 at all times.
- R7: One prescaler clear realigns the taps of both timers at the same time.
- R8: With select 110, the pin reads high and is then first held low in cycle k. This gives exactly one strobe, in cycle k+2.
- R9: With select 111, the pin reads low and is then first held high in cycle k. This gives exactly one strobe, in cycle k+2.
- R10: The pin path is never divided: every qualifying pin edge strobes, and a prescaler clear does not disturb it.
- R11: No strobe is produced while reset is asserted or in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_clk_sel | input | 3*NUM_TIMERS | Per-timer source select, timer t in bits [3t+2:3t] |
| ext_clk_pin | input | NUM_TIMERS | Asynchronous external count pin per timer |
| presc_ctl_wr | input | 1 | Control write strobe for the prescaler clear bit |
| presc_ctl_wdata | input | 1 | Write data for the clear bit; 1 clears, 0 does nothing |
| presc_ctl_rdata | output | 1 | Read-back of the clear bit, always 0 |
| cnt_en | output | NUM_TIMERS | Single-cycle count-enable strobe per timer |

## Verification
The bench aims at tap phase right after a clear. A design that cleared one cycle late, or on a write of zero, would move every later divide-by-8 and divide-by-64 strobe, and the strobe-by-strobe scoreboard catches that. The pin path is driven with irregular high and low times down to two cycles, with a clear in the middle of the burst. A synchronizer one stage short or long, an edge detector of the wrong polarity, or a pin path that goes through the prescaler would show up as shifted, missing or extra strobes. The first cycles after reset and the all-stopped select are checked as well, so a timer that gets an enable before its select allows it is exposed.

// File: rtl/tmrpre_pkg.sv
package tmrpre_pkg;

   localparam int unsigned CS_W     = 3;
   localparam int unsigned NUM_TAPS = 4;

   typedef enum logic [CS_W-1:0] {
      CS_STOP     = 3'd0,
      CS_DIV1     = 3'd1,
      CS_DIV8     = 3'd2,
      CS_DIV64    = 3'd3,
      CS_DIV256   = 3'd4,
      CS_DIV1024  = 3'd5,
      CS_EXT_FALL = 3'd6,
      CS_EXT_RISE = 3'd7
   } clk_sel_e;

   // number of low-order prescaler bits that make up each tap
   function automatic int unsigned tap_bits(int unsigned idx);
      case (idx)
         0:       return 3;
         1:       return 6;
         2:       return 8;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/tmrpre_divider.sv
module tmrpre_divider
   import tmrpre_pkg::*;
#(
   parameter int unsigned PRE_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   output logic [NUM_TAPS-1:0] tap_o
);

   logic [PRE_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear_i) begin
         count_q <= '0;
      end else begin
         count_q <= count_q + PRE_W'(1);
      end
   end

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      localparam int unsigned TW = tap_bits(g);
      if (TW > PRE_W) begin : g_bad
         $error("tmrpre_divider: tap %0d needs %0d bits, PRE_W is %0d", g, TW, PRE_W);
      end
      // tap fires while its low bits are all ones: count rolls to zero next
      assign tap_o[g] = &count_q[TW-1:0];
   end

endmodule

// File: rtl/tmrpre_pin_edge.sv
module tmrpre_pin_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (SYNC_STAGES < 2) begin : g_bad
      $error("tmrpre_pin_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise_o =  sync_q[SYNC_STAGES-1] & ~last_q;
   assign fall_o = ~sync_q[SYNC_STAGES-1] &  last_q;

endmodule

// File: rtl/tmrpre_src_mux.sv
module tmrpre_src_mux
   import tmrpre_pkg::*;
(
   input  logic [CS_W-1:0]     sel_i,
   input  logic [NUM_TAPS-1:0] tap_i,
   input  logic                rise_i,
   input  logic                fall_i,
   input  logic                run_i,
   output logic                en_o
);

   logic pick;

   always_comb begin
      pick = 1'b0;
      case (sel_i)
         CS_STOP:     pick = 1'b0;
         CS_DIV1:     pick = 1'b1;
         CS_DIV8:     pick = tap_i[0];
         CS_DIV64:    pick = tap_i[1];
         CS_DIV256:   pick = tap_i[2];
         CS_DIV1024:  pick = tap_i[3];
         CS_EXT_FALL: pick = fall_i;
         CS_EXT_RISE: pick = rise_i;
         default:     pick = 1'b0;
      endcase
   end

   assign en_o = run_i & pick;

endmodule

// File: rtl/tmrpre_top.sv
module tmrpre_top
   import tmrpre_pkg::*;
#(
   parameter int unsigned NUM_TIMERS  = 2,
   parameter int unsigned PRE_W       = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_TIMERS*CS_W-1:0] tmr_clk_sel,
   input  logic [NUM_TIMERS-1:0]      ext_clk_pin,
   input  logic                       presc_ctl_wr,
   input  logic                       presc_ctl_wdata,
   output logic                       presc_ctl_rdata,
   output logic [NUM_TIMERS-1:0]      cnt_en
);

   if (NUM_TIMERS < 1) begin : g_bad_n
      $error("tmrpre_top: NUM_TIMERS must be at least 1");
   end

   logic                presc_clear;
   logic [NUM_TAPS-1:0] tap_w;
   logic                run_q;

   // write-one clears; the bit is never stored, so it reads back as zero
   assign presc_clear     = presc_ctl_wr & presc_ctl_wdata;
   assign presc_ctl_rdata = 1'b0;

   // holds every strobe off through reset and the first cycle after it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   tmrpre_divider #(.PRE_W(PRE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (presc_clear),
      .tap_o   (tap_w)
   );

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      logic rise_w;
      logic fall_w;

      tmrpre_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (ext_clk_pin[t]),
         .rise_o (rise_w),
         .fall_o (fall_w)
      );

      tmrpre_src_mux u_mux (
         .sel_i  (tmr_clk_sel[t*CS_W +: CS_W]),
         .tap_i  (tap_w),
         .rise_i (rise_w),
         .fall_i (fall_w),
         .run_i  (run_q),
         .en_o   (cnt_en[t])
      );
   end

endmodule

// File: rtl/tmrpre_chk.sv
module tmrpre_div_chk #(
   parameter int unsigned PRE_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear_i,
   input logic [PRE_W-1:0] count_q
);

   // R4: a clear leaves the count at zero on the next cycle
   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (count_q == '0));

   // R3: without a clear the prescaler advances by one each cycle
   p_free_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (count_q == $past(count_q) + PRE_W'(1)));

endmodule

module tmrpre_top_chk
   import tmrpre_pkg::*;
#(
   parameter int unsigned NUM_TIMERS = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_TIMERS*CS_W-1:0] sel,
   input logic [NUM_TIMERS-1:0]      pin,
   input logic                       wr,
   input logic                       wd,
   input logic [NUM_TIMERS-1:0]      en
);

   logic [2:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 3'd7) age <= age + 3'd1;
   end

   // R11: quiet in the first cycle after reset release
   p_first_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd0) |-> (en == '0));

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chk
      logic [CS_W-1:0] s;
      assign s = sel[t*CS_W +: CS_W];

      p_stop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (s == CS_STOP) |-> !en[t]);

      p_div1_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (age != 3'd0 && s == CS_DIV1) |-> en[t]);

      p_div8_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (s == CS_DIV8 && en[t] && !(wr && wd)) |=> (!en[t] || s != CS_DIV8));

      p_fall_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 3'd3 && s == CS_EXT_FALL && en[t]) |-> (!$past(pin[t], 2) && $past(pin[t], 3)));

      p_rise_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 3'd3 && s == CS_EXT_RISE && en[t]) |-> ($past(pin[t], 2) && !$past(pin[t], 3)));
   end

endmodule

bind tmrpre_divider tmrpre_div_chk #(.PRE_W(PRE_W)) u_div_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clear_i (clear_i),
   .count_q (count_q)
);

bind tmrpre_top tmrpre_top_chk #(.NUM_TIMERS(NUM_TIMERS)) u_top_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .sel   (tmr_clk_sel),
   .pin   (ext_clk_pin),
   .wr    (presc_ctl_wr),
   .wd    (presc_ctl_wdata),
   .en    (cnt_en)
);

// File: tb/tmrpre_top_tb.sv
module tmrpre_top_tb;
   import tmrpre_pkg::*;

   localparam int NT = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NT*3-1:0]  sel = '0;
   logic [NT-1:0]    pin = '0;
   logic             wr = 1'b0;
   logic             wd = 1'b0;
   logic             rd;
   logic [NT-1:0]    en;

   int pc = 0;
   int checks = 0;
   int fails = 0;
   int q0[$];
   int q1[$];
   bit mon_on[NT];
   string mon_req[NT];

   tmrpre_top #(.NUM_TIMERS(NT)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .tmr_clk_sel     (sel),
      .ext_clk_pin     (pin),
      .presc_ctl_wr    (wr),
      .presc_ctl_wdata (wd),
      .presc_ctl_rdata (rd),
      .cnt_en          (en)
   );

   always #5 clk = ~clk;
   always @(posedge clk) pc <= pc + 1;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, pc, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic push(int t, int c);
      if (t == 0) q0.push_back(c);
      else        q1.push_back(c);
   endtask

   task automatic close(int t);
      int n;
      mon_on[t] = 1'b0;
      n = (t == 0) ? q0.size() : q1.size();
      check(n == 0, {mon_req[t], " missed strobes"}, n, 0);
      if (t == 0) q0.delete();
      else        q1.delete();
   endtask

   // scoreboard monitor: every watched cycle must match the expected queue
   always @(negedge clk) begin
      if (rst_n) begin
         check(rd == 1'b0, "R6 read-back", int'(rd), 0);
         for (int t = 0; t < NT; t++) begin
            if (mon_on[t]) begin
               bit exp;
               exp = 1'b0;
               if (t == 0) begin
                  if (q0.size() > 0 && q0[0] == pc) begin exp = 1'b1; void'(q0.pop_front()); end
               end else begin
                  if (q1.size() > 0 && q1[0] == pc) begin exp = 1'b1; void'(q1.pop_front()); end
               end
               check(en[t] == exp, mon_req[t], int'(en[t]), int'(exp));
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", pc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int w;
      int k;
      int half[8] = '{2, 3, 5, 2, 4, 3, 2, 6};

      // reset phase: R11 with timer 0 asking for the undivided clock
      sel[2:0] = CS_DIV1;
      tick(); tick();
      #4;
      check(en == '0, "R11 in reset", int'(en), 0);
      check(rd == 1'b0, "R6 in reset", int'(rd), 0);
      tick(); tick();
      rst_n = 1'b1;                          // cycle 4
      #4;
      check(en == '0, "R11 first cycle", int'(en), 0);
      tick();
      #4;
      check(en[0] == 1'b1, "R2 after reset", int'(en[0]), 1);

      // divide-by-8 and divide-by-64 realigned by one clear (R3 R4 R7), zero write (R5)
      tick();
      w = pc;
      sel[2:0] = CS_DIV8;
      sel[5:3] = CS_DIV64;
      wr = 1'b1; wd = 1'b1;
      for (int i = 1; i <= 25; i++) push(0, w + 8*i);
      for (int i = 1; i <= 3; i++)  push(1, w + 64*i);
      tick();
      wr = 1'b0; wd = 1'b0;
      mon_req[0] = "R3 R4 R7 R5 div8";
      mon_req[1] = "R3 R4 R7 div64";
      mon_on[0] = 1'b1; mon_on[1] = 1'b1;
      while (pc < w + 30) tick();
      wr = 1'b1; wd = 1'b0;
      tick();
      wr = 1'b0;
      while (pc < w + 201) tick();
      close(0); close(1);

      // divide-by-256 and divide-by-1024
      tick();
      w = pc;
      sel[2:0] = CS_DIV256;
      sel[5:3] = CS_DIV1024;
      wr = 1'b1; wd = 1'b1;
      for (int i = 1; i <= 4; i++) push(0, w + 256*i);
      push(1, w + 1024);
      tick();
      wr = 1'b0; wd = 1'b0;
      mon_req[0] = "R3 R4 R5 div256";
      mon_req[1] = "R3 R4 R7 div1024";
      mon_on[0] = 1'b1; mon_on[1] = 1'b1;
      while (pc < w + 100) tick();
      wr = 1'b1; wd = 1'b0;
      tick();
      wr = 1'b0;
      while (pc < w + 1101) tick();
      close(0); close(1);

      // external pins: timer 0 on falling edges (R8), timer 1 on rising (R9), clear mid-burst (R10)
      tick();
      sel[2:0] = CS_EXT_FALL;
      sel[5:3] = CS_EXT_RISE;
      repeat (4) tick();
      mon_req[0] = "R8 R10 falling";
      mon_req[1] = "R9 R10 rising";
      mon_on[0] = 1'b1; mon_on[1] = 1'b1;
      k = 0;
      for (int i = 0; i < 8; i++) begin
         repeat (half[i]) begin tick(); wr = 1'b0; wd = 1'b0; end
         pin = ~pin;
         k = pc;
         if (pin[0]) push(1, k + 2);
         else        push(0, k + 2);
         if (i == 3) begin wr = 1'b1; wd = 1'b1; end
      end
      repeat (4) tick();
      close(0); close(1);

      // timer 0 undivided, timer 1 stopped (R2, R1)
      tick();
      w = pc;
      sel[2:0] = CS_DIV1;
      sel[5:3] = CS_STOP;
      mon_req[0] = "R2 div1";
      mon_req[1] = "R1 stopped";
      for (int i = 0; i < 20; i++) push(0, w + i);
      mon_on[0] = 1'b1; mon_on[1] = 1'b1;
      repeat (20) tick();
      close(0); close(1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule